// File: doc/BRIEF.md
# Receive/Transmit Frame Queues

This block buffers frames between a simple Ethernet-style MAC and the software that services it. On the receive side the MAC delivers one byte per cycle and marks the final byte of each frame. The block packs these bytes into a 32-bit word queue. When a frame is accepted, one entry holding the frame's byte count goes into a separate length queue. On the transmit side the MAC pushes one completion record per transmitted frame into a small status queue.

Software reads the length port first. That read consumes one length entry. Software then reads the matching number of words from the word port. Each read of the status port consumes one completion record. Three levels go to an interrupt register block: a frame is waiting, the length queue is empty, and a transmit record is waiting. The length and word queues must never drift apart. Any frame that cannot be stored whole is therefore discarded completely. The word queue rolls back to the end of the last accepted frame.

Top module: `rxtx_frame_queues`

## Requirements
- R1: Byte k of a frame (k counted from 0) lands in word k/4 of that frame at bit positions 8*(k mod 4)+7 down to 8*(k mod 4). Lanes of the final word that no byte reaches read as zero.
- R2: A frame's words and length become readable only after its last byte. `rx_done` first goes high in the cycle after the clock edge that samples the last byte. While a frame is still arriving, none of its words can be read.
- R3: A pulse on `rx_len_rd` removes the oldest length entry. That length appears on `rx_len_rdata` after the same clock edge and holds until the next length read.
- R4: `rx_done` is high exactly when at least one length entry is stored. `rx_len_empty` is its complement. After reset `rx_len_empty` is 1, `rx_done` and `tx_done` are 0, and all read-data outputs are 0.
- R5: A length read while no entry is stored returns 0 and raises `rx_len_underrun` for one cycle. It leaves the queues unchanged.
- R6: A word read while no word of a completed frame is stored returns 0 and raises `rx_word_underrun` for one cycle.
- R7: If the length queue is full when a frame's last byte arrives, the whole frame is discarded (its words and its length). `rx_overrun` pulses in the following cycle, and frames stored earlier read back intact.
- R8: A frame longer than MAX_FRAME bytes, or one whose words do not fit in the word queue's free space, is discarded whole with the same `rx_overrun` pulse. A stored length never exceeds MAX_FRAME.
- R9: `tx_done` is high exactly when at least one transmit record is stored. Each `tx_stat_rd` pulse removes one record and presents it on `tx_stat_rdata`, with bit 0 holding excess deferral and bit 1 holding late collision.
- R10: A record pushed while the status queue is full is lost and `tx_stat_overrun` pulses in the next cycle. A status read while the queue is empty returns 0, raises `tx_stat_underrun` and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_valid | input | 1 | Receive byte strobe from the MAC |
| rx_byte | input | 8 | Receive byte |
| rx_byte_last | input | 1 | Marks the final byte of a frame |
| rx_len_rd | input | 1 | Software read of the length port (consumes) |
| rx_len_rdata | output | $clog2(MAX_FRAME+1) | Length returned by the last length read |
| rx_word_rd | input | 1 | Software read of the word port (consumes) |
| rx_word_rdata | output | 32 | Word returned by the last word read |
| rx_len_underrun | output | 1 | Pulse: length read found no entry |
| rx_word_underrun | output | 1 | Pulse: word read found no committed word |
| rx_overrun | output | 1 | Pulse: a complete frame was discarded |
| rx_done | output | 1 | Level: at least one frame waiting |
| rx_len_empty | output | 1 | Level: length queue empty |
| tx_stat_push | input | 1 | MAC pushes one transmit completion record |
| tx_excess_defer | input | 1 | Record flag: excess deferral |
| tx_late_coll | input | 1 | Record flag: late collision |
| tx_stat_rd | input | 1 | Software read of the status port (consumes) |
| tx_stat_rdata | output | 2 | Record returned by the last status read |
| tx_stat_underrun | output | 1 | Pulse: status read found no record |
| tx_stat_overrun | output | 1 | Pulse: record pushed into a full queue was lost |
| tx_done | output | 1 | Level: at least one transmit record waiting |

## Verification
The bound checker tests several rules on every cycle:
- `rx_done` rises only right after a last byte and falls only after a length read.
- A discard pulse follows only a last byte.
- Underrun reads always return zero.
- A returned length never exceeds MAX_FRAME.
- A record pushed into a non-full status queue raises `tx_done`.

Only the bench's scenarios can show the rest:
- Byte-lane packing and zero fill.
- Whole-frame rollback when the word queue or length queue runs out of room, and that the frames stored before it stay intact.
- That partially received frames stay invisible.
- Consume-once ordering across long mixed sequences of frames.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
   localparam int unsigned ETH_MAX_FRAME = 1518;
   localparam int unsigned WORD_W        = 32;
   localparam int unsigned LANES         = WORD_W / 8;

   typedef struct packed {
      logic late_coll;
      logic excess_defer;
   } tx_rec_t;
endpackage

// File: rtl/pfq_ring.sv
// Circular queue. With ROLLBACK set, writes are speculative until commit;
// rewind discards everything written since the last commit.
module pfq_ring #(
   parameter int unsigned W        = 32,
   parameter int unsigned DEPTH    = 16,
   parameter bit          ROLLBACK = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   input  logic         commit,
   input  logic         rewind,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr, vis_ptr;
   logic         do_push, do_pop;

   assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
   assign empty   = (vis_ptr == rptr);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rptr <= '0;
      else if (do_pop) rptr <= rptr + 1'b1;
   end

   generate
      if (ROLLBACK) begin : g_spec
         logic [AW:0] cptr;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wptr <= '0;
               cptr <= '0;
            end else begin
               if (rewind)       wptr <= cptr;
               else if (do_push) wptr <= wptr + 1'b1;
               if (commit && !rewind) cptr <= wptr + {{AW{1'b0}}, do_push};
            end
         end
         assign vis_ptr = cptr;
      end else begin : g_plain
         logic unused_ctl;
         assign unused_ctl = commit ^ rewind;
         always_ff @(posedge clk) begin
            if (!rst_n)       wptr <= '0;
            else if (do_push) wptr <= wptr + 1'b1;
         end
         assign vis_ptr = wptr;
      end
   endgenerate
endmodule

// File: rtl/pfq_packer.sv
// Packs receive bytes into words, counts the frame and decides at the last
// byte whether the frame is kept or discarded.
module pfq_packer
   import pfq_pkg::*;
#(
   parameter int unsigned MAX_FRAME = ETH_MAX_FRAME,
   parameter int unsigned LEN_W     = $clog2(MAX_FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_last,
   input  logic              data_full,
   input  logic              len_full,
   output logic              data_push,
   output logic [WORD_W-1:0] data_word,
   output logic              data_commit,
   output logic              data_rewind,
   output logic              len_push,
   output logic [LEN_W-1:0]  len_value,
   output logic              frame_drop
);
   logic [LEN_W-1:0]  cnt;
   logic [WORD_W-1:0] acc;
   logic              bad_q;
   logic [1:0]        lane;
   logic              over_max, want_push, lost, bad_now, lane_end;
   logic [WORD_W-1:0] shifted;

   assign lane      = cnt[1:0];
   assign lane_end  = (lane == 2'd3);
   assign shifted   = {{(WORD_W-8){1'b0}}, in_byte} << {lane, 3'b000};
   assign data_word = acc | shifted;
   assign over_max  = (cnt >= LEN_W'(MAX_FRAME));
   assign want_push = in_valid && (lane_end || in_last);
   assign lost      = want_push && data_full && !bad_q;
   assign bad_now   = bad_q || lost || (in_valid && over_max);

   assign data_push   = want_push && !bad_now;
   assign data_commit = in_valid && in_last && !bad_now && !len_full;
   assign data_rewind = in_valid && in_last && !data_commit;
   assign len_push    = data_commit;
   assign len_value   = cnt + 1'b1;
   assign frame_drop  = data_rewind;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc   <= '0;
         bad_q <= 1'b0;
      end else if (in_valid) begin
         if (in_last) begin
            cnt   <= '0;
            acc   <= '0;
            bad_q <= 1'b0;
         end else begin
            cnt   <= over_max ? cnt : cnt + 1'b1;
            acc   <= lane_end ? '0 : data_word;
            bad_q <= bad_now;
         end
      end
   end
endmodule

// File: rtl/rxtx_frame_queues.sv
module rxtx_frame_queues
   import pfq_pkg::*;
#(
   parameter int unsigned MAX_FRAME  = ETH_MAX_FRAME,
   parameter int unsigned DATA_DEPTH = 64,
   parameter int unsigned LEN_DEPTH  = 8,
   parameter int unsigned STAT_DEPTH = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rx_byte_valid,
   input  logic [7:0]                       rx_byte,
   input  logic                             rx_byte_last,
   input  logic                             rx_len_rd,
   output logic [$clog2(MAX_FRAME+1)-1:0]   rx_len_rdata,
   input  logic                             rx_word_rd,
   output logic [31:0]                      rx_word_rdata,
   output logic                             rx_len_underrun,
   output logic                             rx_word_underrun,
   output logic                             rx_overrun,
   output logic                             rx_done,
   output logic                             rx_len_empty,
   input  logic                             tx_stat_push,
   input  logic                             tx_excess_defer,
   input  logic                             tx_late_coll,
   input  logic                             tx_stat_rd,
   output logic [1:0]                       tx_stat_rdata,
   output logic                             tx_stat_underrun,
   output logic                             tx_stat_overrun,
   output logic                             tx_done
);
   localparam int unsigned LEN_W = $clog2(MAX_FRAME + 1);

   generate
      if (DATA_DEPTH < 2 || (DATA_DEPTH & (DATA_DEPTH - 1)) != 0) begin : g_bad_data
         $error("DATA_DEPTH must be a power of two of at least 2");
      end
      if (LEN_DEPTH < 2 || (LEN_DEPTH & (LEN_DEPTH - 1)) != 0) begin : g_bad_len
         $error("LEN_DEPTH must be a power of two of at least 2");
      end
      if (STAT_DEPTH < 2 || (STAT_DEPTH & (STAT_DEPTH - 1)) != 0) begin : g_bad_stat
         $error("STAT_DEPTH must be a power of two of at least 2");
      end
      if (MAX_FRAME < 4) begin : g_bad_max
         $error("MAX_FRAME must be at least 4");
      end
   endgenerate

   // receive path
   logic              d_push, d_commit, d_rewind, d_empty, d_full;
   logic [WORD_W-1:0] d_wword, d_head;
   logic              l_push, l_empty, l_full;
   logic [LEN_W-1:0]  l_wval, l_head;
   logic              drop;

   pfq_packer #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) i_packer (
      .clk, .rst_n,
      .in_valid(rx_byte_valid), .in_byte(rx_byte), .in_last(rx_byte_last),
      .data_full(d_full), .len_full(l_full),
      .data_push(d_push), .data_word(d_wword),
      .data_commit(d_commit), .data_rewind(d_rewind),
      .len_push(l_push), .len_value(l_wval), .frame_drop(drop)
   );

   pfq_ring #(.W(WORD_W), .DEPTH(DATA_DEPTH), .ROLLBACK(1'b1)) i_words (
      .clk, .rst_n, .push(d_push), .wdata(d_wword), .pop(rx_word_rd),
      .commit(d_commit), .rewind(d_rewind),
      .rdata(d_head), .empty(d_empty), .full(d_full)
   );

   pfq_ring #(.W(LEN_W), .DEPTH(LEN_DEPTH), .ROLLBACK(1'b0)) i_lens (
      .clk, .rst_n, .push(l_push), .wdata(l_wval), .pop(rx_len_rd),
      .commit(1'b0), .rewind(1'b0),
      .rdata(l_head), .empty(l_empty), .full(l_full)
   );

   // transmit path
   tx_rec_t t_in, t_head;
   logic    t_empty, t_full;

   assign t_in = '{late_coll: tx_late_coll, excess_defer: tx_excess_defer};

   pfq_ring #(.W($bits(tx_rec_t)), .DEPTH(STAT_DEPTH), .ROLLBACK(1'b0)) i_stats (
      .clk, .rst_n, .push(tx_stat_push), .wdata(t_in), .pop(tx_stat_rd),
      .commit(1'b0), .rewind(1'b0),
      .rdata(t_head), .empty(t_empty), .full(t_full)
   );

   // software-facing read registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_len_rdata     <= '0;
         rx_word_rdata    <= '0;
         tx_stat_rdata    <= '0;
         rx_len_underrun  <= 1'b0;
         rx_word_underrun <= 1'b0;
         tx_stat_underrun <= 1'b0;
         tx_stat_overrun  <= 1'b0;
         rx_overrun       <= 1'b0;
      end else begin
         rx_len_underrun  <= rx_len_rd && l_empty;
         rx_word_underrun <= rx_word_rd && d_empty;
         tx_stat_underrun <= tx_stat_rd && t_empty;
         tx_stat_overrun  <= tx_stat_push && t_full;
         rx_overrun       <= drop;
         if (rx_len_rd)  rx_len_rdata  <= l_empty ? '0 : l_head;
         if (rx_word_rd) rx_word_rdata <= d_empty ? '0 : d_head;
         if (tx_stat_rd) tx_stat_rdata <= t_empty ? '0 : t_head;
      end
   end

   assign rx_done      = !l_empty;
   assign rx_len_empty = l_empty;
   assign tx_done      = !t_empty;
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
   parameter int unsigned MAX_FRAME = 1518
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           rx_byte_valid,
   input logic                           rx_byte_last,
   input logic                           rx_len_rd,
   input logic [$clog2(MAX_FRAME+1)-1:0] rx_len_rdata,
   input logic [31:0]                    rx_word_rdata,
   input logic                           rx_len_underrun,
   input logic                           rx_word_underrun,
   input logic                           rx_overrun,
   input logic                           rx_done,
   input logic                           rx_len_empty,
   input logic                           tx_stat_push,
   input logic                           tx_stat_rd,
   input logic [1:0]                     tx_stat_rdata,
   input logic                           tx_stat_underrun,
   input logic                           tx_stat_overrun,
   input logic                           tx_done
);
   localparam int unsigned LEN_W = $clog2(MAX_FRAME + 1);

   p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(rx_byte_valid && rx_byte_last));

   p_done_falls_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_done) |-> $past(rx_len_rd));

   p_len_underrun_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_len_rd && rx_len_empty) |=> (rx_len_underrun && rx_len_rdata == '0));

   p_word_underrun_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_word_underrun |-> (rx_word_rdata == '0));

   p_drop_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> $past(rx_byte_valid && rx_byte_last));

   p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_len_rdata <= LEN_W'(MAX_FRAME));

   p_tx_done_on_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_stat_push && !tx_stat_rd) |=> tx_done);

   p_tx_overrun_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stat_overrun |-> $past(tx_done));

   p_tx_underrun_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stat_underrun |-> (tx_stat_rdata == 2'b00));
endmodule

bind rxtx_frame_queues pfq_checker #(.MAX_FRAME(MAX_FRAME)) i_pfq_checker (.*);

// File: tb/test_rxtx_frame_queues.sv
`timescale 1ns/1ps
module test_rxtx_frame_queues;
   localparam int MAXF = 40;
   localparam int DD   = 16;
   localparam int LD   = 4;
   localparam int SD   = 4;
   localparam int LW   = $clog2(MAXF + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_byte_valid = 0, rx_byte_last = 0, rx_len_rd = 0, rx_word_rd = 0;
   logic [7:0] rx_byte = 0;
   logic tx_stat_push = 0, tx_excess_defer = 0, tx_late_coll = 0, tx_stat_rd = 0;
   logic [LW-1:0] rx_len_rdata;
   logic [31:0] rx_word_rdata;
   logic rx_len_underrun, rx_word_underrun, rx_overrun, rx_done, rx_len_empty;
   logic [1:0] tx_stat_rdata;
   logic tx_stat_underrun, tx_stat_overrun, tx_done;

   always #4 clk = ~clk;

   rxtx_frame_queues #(.MAX_FRAME(MAXF), .DATA_DEPTH(DD), .LEN_DEPTH(LD), .STAT_DEPTH(SD))
   i_rxtx_frame_queues (.*);

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   int lq[$];
   logic [31:0] wq[$];
   logic [1:0] sq[$];
   logic [7:0] fb[64];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [31:0] pack_word(input int len, input int w);
      logic [31:0] v = '0;
      for (int b = 0; b < 4; b++)
         if (4*w + b < len) v[8*b +: 8] = fb[4*w + b];
      return v;
   endfunction

   // decides acceptance from requirement R7/R8 and records expected content
   function automatic bit model_frame(input int len);
      int nw = (len + 3) / 4;
      bit drop = (len > MAXF) || (wq.size() + nw > DD) || (lq.size() == LD);
      if (!drop) begin
         lq.push_back(len);
         for (int w = 0; w < nw; w++) wq.push_back(pack_word(len, w));
      end
      return drop;
   endfunction

   task automatic push_byte(input logic [7:0] b, input logic last);
      @(negedge clk);
      rx_byte_valid = 1; rx_byte = b; rx_byte_last = last;
   endtask

   task automatic idle();
      @(negedge clk);
      rx_byte_valid = 0; rx_byte_last = 0; rx_len_rd = 0; rx_word_rd = 0;
      tx_stat_push = 0; tx_stat_rd = 0;
   endtask

   task automatic send_frame(input int len, input string req);
      bit drop;
      for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
      drop = model_frame(len);
      for (int k = 0; k < len; k++) push_byte(fb[k], k == len - 1);
      idle();
      chk({req, " overrun"}, rx_overrun, drop);
      chk("R4 done level", rx_done, lq.size() != 0);
   endtask

   task automatic read_frame();
      int len = lq.pop_front();
      @(negedge clk); rx_len_rd = 1;
      idle();
      chk("R3 length", rx_len_rdata, len);
      chk("R5 no underrun", rx_len_underrun, 0);
      for (int w = 0; w < (len + 3) / 4; w++) begin
         @(negedge clk); rx_word_rd = 1;
         idle();
         chk("R1 word", rx_word_rdata, wq.pop_front());
      end
      chk("R4 empty flag", rx_len_empty, lq.size() == 0);
   endtask

   task automatic push_stat(input logic [1:0] s);
      bit full = (sq.size() == SD);
      @(negedge clk); tx_stat_push = 1; tx_late_coll = s[1]; tx_excess_defer = s[0];
      idle();
      chk("R10 tx overrun", tx_stat_overrun, full);
      if (!full) sq.push_back(s);
      chk("R9 tx done", tx_done, 1);
   endtask

   task automatic read_stat();
      bit emp = (sq.size() == 0);
      @(negedge clk); tx_stat_rd = 1;
      idle();
      chk("R10 tx underrun", tx_stat_underrun, emp);
      chk("R9 tx record", tx_stat_rdata, emp ? 2'b00 : sq.pop_front());
      chk("R9 tx done level", tx_done, sq.size() != 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int seed_val;
      seed_val = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R4 reset state
      chk("R4 reset empty", rx_len_empty, 1);
      chk("R4 reset done", rx_done, 0);
      chk("R4 reset tx done", tx_done, 0);
      chk("R4 reset len data", rx_len_rdata, 0);

      // R5 / R6 underrun on empty queues
      @(negedge clk); rx_len_rd = 1; idle();
      chk("R5 len underrun", rx_len_underrun, 1);
      chk("R5 len zero", rx_len_rdata, 0);
      @(negedge clk); rx_word_rd = 1; idle();
      chk("R6 word underrun", rx_word_underrun, 1);
      chk("R6 word zero", rx_word_rdata, 0);

      // R1 five-byte frame, partial final word zero filled
      send_frame(5, "R1");
      read_frame();
      chk("R3 done falls", rx_done, 0);

      // R2/R6 partially received frame is invisible
      for (int k = 0; k < 6; k++) fb[k] = 8'(8'hA0 + k);
      for (int k = 0; k < 5; k++) push_byte(fb[k], 0);
      @(negedge clk); rx_byte_valid = 0; rx_word_rd = 1;
      idle();
      chk("R6 partial frame hidden", rx_word_underrun, 1);
      chk("R2 done low mid-frame", rx_done, 0);
      chk("R7 model", model_frame(6), 0);
      push_byte(fb[5], 1);
      idle();
      chk("R2 done after last", rx_done, 1);
      read_frame();

      // R7 length queue full: fifth frame discarded
      for (int i = 0; i < LD + 1; i++) send_frame(1 + i, "R7");
      while (lq.size() != 0) read_frame();

      // R8 oversize and boundary
      send_frame(MAXF + 1, "R8 oversize");
      send_frame(MAXF, "R8 max size");
      send_frame(MAXF, "R8 no word space");
      send_frame(24, "R8 exact fit");
      while (lq.size() != 0) read_frame();

      // mixed random traffic
      for (int i = 0; i < 80; i++) begin
         if (($urandom % 3 == 0) && lq.size() != 0) read_frame();
         else send_frame(1 + $urandom % (MAXF + 4), "R7 R8 random");
      end
      while (lq.size() != 0) read_frame();
      chk("R4 drained", rx_len_empty, 1);

      // R9/R10 transmit records
      read_stat();
      for (int i = 0; i < SD + 1; i++) push_stat(2'($urandom));
      for (int i = 0; i < SD + 1; i++) read_stat();
      for (int i = 0; i < 30; i++) begin
         if ($urandom % 2) push_stat(2'($urandom)); else read_stat();
      end

      finished = 1;
      summary();
      $finish;
   end
endmodule